// File: doc/BRIEF.md
# QR Format Information Encoder

This block produces the 15-bit format word that a QR symbol carries next to its finder patterns. It takes a 2-bit error-correction level and a 3-bit mask-pattern index and joins them into a 5-bit data value. A serial divider then finds the 10-bit BCH check field, taking one data bit per clock. The divider works over GF(2), where addition and subtraction are both XOR, and is built as a 10-bit shift register with feedback taps. The check field is placed after the data bits, and the 15-bit result is XORed with a fixed scrambling constant.

A caller pulses `start` while the block is idle. The block samples the two inputs on that edge and runs for five cycles. It then raises `done` for one cycle. `fmt_word` keeps its value until the next accepted start.

Top module: `qr_fmt_encoder`

## Requirements
- R1: The data value is `{ecc_level, mask_sel}`, with the level in the two upper bits. The level codes are L=2'b01, M=2'b00, Q=2'b11 and H=2'b10.
- R2: The check field is the remainder of (data × x^10) divided by the generator x^10+x^8+x^5+x^4+x^2+x+1, which is 11'b10100110111, over GF(2).
- R3: `fmt_word` = {data, check field} XOR 15'b101010000010010. Bit 14 holds the MSB of the level and bit 0 holds the LSB of the check field.
- R4: When the data value is 00000 (level M, mask 0), `fmt_word` equals 15'b101010000010010 exactly.
- R5: A start is accepted when `start` is high on a clock edge while `busy` is low. `busy` then stays high for five cycles. `done` is high for exactly one cycle, which begins at the fifth edge after the accepting edge, and `busy` is low during that cycle.
- R6: While `busy` is high, `start` and any change on the inputs have no effect on the result of the run in progress.
- R7: After `done`, `fmt_word` holds its value until the next accepted start, even if the inputs change.
- R8: After reset, `busy` and `done` are low and `fmt_word` equals 15'b101010000010010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to encode; sampled only while idle |
| ecc_level | input | 2 | Error-correction level code |
| mask_sel | input | 3 | Mask pattern index |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse when `fmt_word` becomes valid |
| fmt_word | output | 15 | Scrambled format word |

## Verification
The bench runs all 32 level and mask pairs and compares each result with a remainder it computes by long division. A tap placed on the wrong bit, or bits taken in reverse order, would give wrong words for most of these pairs. The all-zero data case is checked on its own: a wrong scrambling constant, or a check field that is not cleared before the run, would show up there. The bench also sends a second start in the middle of a run and changes the inputs after `done`. A design that accepted the second start, or kept following its inputs, would put out the wrong word or lose the held one. The `done` latency is counted cycle by cycle, so a divider that runs one bit too many or one too few would be caught.

// File: rtl/qr_fmt_pkg.sv
package qr_fmt_pkg;
   typedef enum logic [1:0] {
      LVL_M = 2'b00,
      LVL_L = 2'b01,
      LVL_H = 2'b10,
      LVL_Q = 2'b11
   } fmt_level_e;

   localparam logic [10:0] FMT_GEN_DEFAULT  = 11'b10100110111;
   localparam logic [14:0] FMT_MASK_DEFAULT = 15'b101010000010010;
endpackage

// File: rtl/qr_fmt_lfsr.sv
module qr_fmt_lfsr #(
   parameter int                 REM_W    = 10,
   parameter logic [REM_W:0]     GEN_POLY = 11'b10100110111
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             shift,
   input  logic             din,
   output logic [REM_W-1:0] rem
);
   logic [REM_W-1:0] rem_q;
   logic [REM_W-1:0] rem_nxt;
   logic             fb;

   assign fb = din ^ rem_q[REM_W-1];

   for (genvar i = 0; i < REM_W; i++) begin : g_tap
      if (i == 0) begin : g_lsb
         assign rem_nxt[i] = fb & GEN_POLY[i];
      end else begin : g_mid
         assign rem_nxt[i] = rem_q[i-1] ^ (fb & GEN_POLY[i]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rem_q <= '0;
      else if (clr)   rem_q <= '0;
      else if (shift) rem_q <= rem_nxt;
   end

   assign rem = rem_q;
endmodule

// File: rtl/qr_fmt_seq.sv
module qr_fmt_seq #(
   parameter int  DATA_W = 5,
   localparam int CNT_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic             accept,
   output logic             busy,
   output logic             done,
   output logic [CNT_W-1:0] bit_cnt
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

   logic busy_q, done_q;
   logic [CNT_W-1:0] cnt_q;

   assign accept = start & ~busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         cnt_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
         end else if (busy_q) begin
            if (cnt_q == LAST) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign busy    = busy_q;
   assign done    = done_q;
   assign bit_cnt = cnt_q;
endmodule

// File: rtl/qr_fmt_encoder.sv
module qr_fmt_encoder #(
   parameter int                         LVL_W    = 2,
   parameter int                         SEL_W    = 3,
   parameter int                         REM_W    = 10,
   parameter logic [REM_W:0]             GEN_POLY = 11'b10100110111,
   parameter logic [LVL_W+SEL_W+REM_W-1:0] XOR_MASK = 15'b101010000010010,
   localparam int DATA_W = LVL_W + SEL_W,
   localparam int WORD_W = DATA_W + REM_W,
   localparam int CNT_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [LVL_W-1:0]  ecc_level,
   input  logic [SEL_W-1:0]  mask_sel,
   output logic              busy,
   output logic              done,
   output logic [WORD_W-1:0] fmt_word
);
   if (GEN_POLY[REM_W] != 1'b1) begin : g_bad_gen_msb
      $error("generator must have its top coefficient set");
   end
   if (GEN_POLY[0] != 1'b1) begin : g_bad_gen_lsb
      $error("generator must have a nonzero constant term");
   end
   if (LVL_W < 1 || SEL_W < 1 || REM_W < 1) begin : g_bad_width
      $error("field widths must be positive");
   end

   logic              accept;
   logic [CNT_W-1:0]  bit_cnt;
   logic [DATA_W-1:0] data_q;
   logic [REM_W-1:0]  rem;
   logic              cur_bit;

   qr_fmt_seq #(.DATA_W(DATA_W)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .accept  (accept),
      .busy    (busy),
      .done    (done),
      .bit_cnt (bit_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      data_q <= '0;
      else if (accept) data_q <= {ecc_level, mask_sel};
   end

   assign cur_bit = data_q[CNT_W'(DATA_W - 1) - bit_cnt];

   qr_fmt_lfsr #(.REM_W(REM_W), .GEN_POLY(GEN_POLY)) u_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (accept),
      .shift (busy),
      .din   (cur_bit),
      .rem   (rem)
   );

   assign fmt_word = {data_q, rem} ^ XOR_MASK;
endmodule

// File: rtl/qr_fmt_encoder_chk.sv
module qr_fmt_encoder_chk #(
   parameter int                DATA_W   = 5,
   parameter int                WORD_W   = 15,
   parameter logic [WORD_W-1:0] XOR_MASK = 15'b101010000010010
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic [DATA_W-1:0] data_q,
   input logic [WORD_W-1:0] fmt_word
);
   a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   a_r5_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);
   a_r5_done_follows_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(busy));
   a_r6_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> $stable(data_q));
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(fmt_word));
   a_r4_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
      (done && data_q == '0) |-> (fmt_word == XOR_MASK));
endmodule

bind qr_fmt_encoder qr_fmt_encoder_chk #(
   .DATA_W   (DATA_W),
   .WORD_W   (WORD_W),
   .XOR_MASK (XOR_MASK)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .busy     (busy),
   .done     (done),
   .data_q   (data_q),
   .fmt_word (fmt_word)
);

// File: tb/qr_fmt_encoder_tb.sv
module qr_fmt_encoder_tb;
   import qr_fmt_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  ecc_level = '0;
   logic [2:0]  mask_sel = '0;
   logic        busy, done;
   logic [14:0] fmt_word;

   int total = 0;
   int bad   = 0;
   bit finished = 1'b0;

   localparam logic [14:0] SCRAMBLE = 15'b101010000010010;
   localparam logic [10:0] GEN      = 11'b10100110111;

   always #4 clk = ~clk;

   qr_fmt_encoder u_dut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .ecc_level(ecc_level), .mask_sel(mask_sel),
      .busy(busy), .done(done), .fmt_word(fmt_word)
   );

   function automatic logic [14:0] ref_word(input logic [4:0] d);
      logic [14:0] v;
      v = {d, 10'b0};
      for (int i = 14; i >= 10; i--)
         if (v[i]) v = v ^ (15'(GEN) << (i - 10));
      return {d, v[9:0]} ^ SCRAMBLE;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run(input logic [1:0] lvl, input logic [2:0] ms, output int lat);
      @(negedge clk);
      ecc_level = lvl; mask_sel = ms; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      while (!done && lat < 20) begin
         @(negedge clk);
         lat++;
      end
   endtask

   initial begin
      int lat;
      repeat (3) @(negedge clk);
      check("R8 busy", 32'(busy), 0);
      check("R8 done", 32'(done), 0);
      check("R8 word", 32'(fmt_word), 32'(SCRAMBLE));
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R2 R3: sweep of all level and mask pairs
      for (int d = 0; d < 32; d++) begin
         run(d[4:3], d[2:0], lat);
         check("R5 latency", 32'(lat), 5);
         check("R5 idle at done", 32'(busy), 0);
         check("R2 R3 word", 32'(fmt_word), 32'(ref_word(d[4:0])));
         @(negedge clk);
         check("R5 done one cycle", 32'(done), 0);
      end

      // R4: level M, mask 0
      run(LVL_M, 3'd0, lat);
      check("R4 zero data", 32'(fmt_word), 32'(SCRAMBLE));
      // R1: level L, mask 0 has a known word
      run(LVL_L, 3'd0, lat);
      check("R1 level L mask0", 32'(fmt_word), 32'(15'b111011111000100));

      // R6: second start while busy is ignored
      @(negedge clk);
      ecc_level = LVL_Q; mask_sel = 3'd5; start = 1'b1;
      @(negedge clk);
      ecc_level = LVL_H; mask_sel = 3'd2;
      @(negedge clk);
      start = 1'b0;
      check("R6 still busy", 32'(busy), 1);
      lat = 1;
      while (!done && lat < 20) begin @(negedge clk); lat++; end
      check("R6 latency", 32'(lat), 5);
      check("R6 word", 32'(fmt_word), 32'(ref_word({LVL_Q, 3'd5})));

      // R7: output holds when inputs move without a start
      ecc_level = LVL_L; mask_sel = 3'd7;
      repeat (6) @(negedge clk);
      check("R7 hold", 32'(fmt_word), 32'(ref_word({LVL_Q, 3'd5})));
      check("R7 idle", 32'(busy), 0);

      finished = 1'b1;
   end

   initial begin
      for (int c = 0; c < 5000 && !finished; c++) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule